// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home agent of a two-level cache hierarchy. It owns the backing data for a small set of lines and a directory entry per line that records which child caches hold the line and with what rights. Child caches send it requests for a shared (read) copy or an exclusive (write) copy. They also send replies: an invalidate acknowledge, a write-back that keeps a shared copy, or a flush that gives the copy up. The controller answers with grants (shared or exclusive reply) or with recalls (invalidate, write-back or flush requests) sent to the children that stand in the way.

Each line is in one of four states: shared with a sharer bit vector (an empty vector means uncached), owned by one writer, or one of two transient states that wait for invalidate acknowledges or for the owner's data. A request that cannot be granted stays at the head of the request input. The controller issues the recall once and then retries the request each cycle until the replies have resolved the transient state. Replies come in on a separate input that is accepted on every cycle, so a stalled request can never keep a reply from draining.

Top module: `homeDirectory`

## Requirements
- R1: After reset every line is shared with an empty sharer vector, every line's data is zero, and outValid is low until a message is produced.
- R2: A shared request (reqEx=0) to a line in the shared state is dequeued in the same cycle (reqReady high). The requester is added to the sharers. One cycle later the controller sends a shared reply (outCmd=0) to the requester only, carrying the line's data.
- R3: An exclusive request (reqEx=1) to a shared line whose sharer vector is empty or holds only the requester is dequeued. The line becomes owned by the requester, and one cycle later an exclusive reply (outCmd=1) carrying the data goes to the requester only.
- R4: An exclusive request to a shared line with other sharers is not dequeued. One cycle later a single invalidate request (outCmd=2) goes to exactly those other sharers, and the line enters the invalidating transient state.
- R5: A request to an owned line is not dequeued and recalls the line from its owner: a write-back request (outCmd=3) for a shared request, a flush request (outCmd=4) for an exclusive request. The line enters the owner-recall transient state.
- R6: A request to a line in either transient state is not dequeued and produces no message.
- R7: An invalidate acknowledge (rspCmd=0) removes the sender from the sharer vector. When the invalidating state's vector becomes empty the line returns to shared-uncached, and the waiting exclusive request is granted on its next try.
- R8: A write-back reply (rspCmd=1) stores rspData as the line's data and leaves the sender as the only sharer.
- R9: A flush reply (rspCmd=2) stores rspData as the line's data and leaves the line with no sharer.
- R10: While rspValid is high the reply is consumed, the request input is not dequeued, and no message is produced for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is at the head of the request input |
| reqSrc | input | ID_W | Requesting child index |
| reqEx | input | 1 | 0 = shared request, 1 = exclusive request |
| reqLine | input | LINE_W | Line addressed by the request |
| reqReady | output | 1 | The head request is dequeued this cycle |
| rspValid | input | 1 | A child reply is present (always consumed) |
| rspSrc | input | ID_W | Replying child index |
| rspCmd | input | 2 | 0 invalidate ack, 1 write-back, 2 flush |
| rspLine | input | LINE_W | Line addressed by the reply |
| rspData | input | DATA_W | Data carried by write-back or flush |
| outValid | output | 1 | Outgoing message valid (one cycle) |
| outCmd | output | 3 | 0 shared reply, 1 exclusive reply, 2 invalidate, 3 write-back req, 4 flush req |
| outDst | output | NUM_CHILD | Destination children, one bit each |
| outLine | output | LINE_W | Line of the outgoing message |
| outData | output | DATA_W | Line data (meaningful on replies) |

## Verification
The main function is driven with three kinds of pattern. A sequence of shared requests that accumulate sharers separates correct sharer tracking from a controller that only remembers the last reader. An exclusive request is then placed against a line with several sharers, and its acknowledges are fed one at a time while the request stays at the head. This shows that the grant waits for the last acknowledge rather than the first, and that replies still drain during the stall. Finally, ownership recalls by shared and by exclusive requests, answered with write-back and with flush, show whether returned data reaches memory and whether the former owner is kept or dropped as a sharer. The following grant or invalidate tells the two apart.

// File: rtl/homeDirPkg.sv
`timescale 1ns/1ps
package homeDirPkg;

  typedef enum logic [1:0] {
    LK_SHARED  = 2'd0,
    LK_OWNED   = 2'd1,
    LK_INVWAIT = 2'd2,
    LK_RECALL  = 2'd3
  } lineKind_e;

  typedef enum logic [2:0] {
    MC_SHREP   = 3'd0,
    MC_EXREP   = 3'd1,
    MC_INVREQ  = 3'd2,
    MC_WBREQ   = 3'd3,
    MC_FLUSHRQ = 3'd4
  } msgCmd_e;

  localparam logic [1:0] RC_INVACK = 2'd0;
  localparam logic [1:0] RC_WBACK  = 2'd1;
  localparam logic [1:0] RC_FLUSH  = 2'd2;

  typedef struct packed {
    logic      wrState;
    lineKind_e newKind;
    logic      wrMem;
    logic      sendMsg;
    msgCmd_e   cmd;
  } ctlStrobe_t;

endpackage

// File: rtl/homeDirCtl.sv
`timescale 1ns/1ps
module homeDirCtl
  import homeDirPkg::*;
#(
  parameter int NUM_CHILD = 4,
  localparam int ID_W = $clog2(NUM_CHILD)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqSrc,
  input  logic                 reqEx,
  input  logic                 rspValid,
  input  logic [ID_W-1:0]      rspSrc,
  input  logic [1:0]           rspCmd,
  input  lineKind_e            curKind,
  input  logic [NUM_CHILD-1:0] curDir,
  input  logic [ID_W-1:0]      curOwner,
  output logic                 reqReady,
  output ctlStrobe_t           strobe,
  output logic [NUM_CHILD-1:0] newDir,
  output logic [ID_W-1:0]      newOwner,
  output logic [NUM_CHILD-1:0] msgDst
);

  logic [NUM_CHILD-1:0] reqMask, rspMask, otherSharers, ownerMask;

  assign reqMask      = NUM_CHILD'(1) << reqSrc;
  assign rspMask      = NUM_CHILD'(1) << rspSrc;
  assign ownerMask    = NUM_CHILD'(1) << curOwner;
  assign otherSharers = curDir & ~reqMask;

  always_comb begin
    strobe   = '{wrState: 1'b0, newKind: curKind, wrMem: 1'b0,
                 sendMsg: 1'b0, cmd: MC_SHREP};
    newDir   = curDir;
    newOwner = curOwner;
    msgDst   = '0;
    reqReady = 1'b0;
    if (rspValid) begin
      unique case (rspCmd)
        RC_INVACK: begin
          strobe.wrState = 1'b1;
          newDir = curDir & ~rspMask;
          if (curKind == LK_INVWAIT && newDir == '0) strobe.newKind = LK_SHARED;
        end
        RC_WBACK: begin
          strobe.wrState = 1'b1;
          strobe.wrMem   = 1'b1;
          strobe.newKind = LK_SHARED;
          newDir = rspMask;
        end
        RC_FLUSH: begin
          strobe.wrState = 1'b1;
          strobe.wrMem   = 1'b1;
          strobe.newKind = LK_SHARED;
          newDir = '0;
        end
        default: ;
      endcase
    end else if (reqValid) begin
      unique case (curKind)
        LK_SHARED: begin
          strobe.wrState = 1'b1;
          strobe.sendMsg = 1'b1;
          if (!reqEx) begin
            reqReady   = 1'b1;
            newDir     = curDir | reqMask;
            strobe.cmd = MC_SHREP;
            msgDst     = reqMask;
          end else if (otherSharers == '0) begin
            reqReady       = 1'b1;
            strobe.newKind = LK_OWNED;
            newDir         = '0;
            newOwner       = reqSrc;
            strobe.cmd     = MC_EXREP;
            msgDst         = reqMask;
          end else begin
            strobe.newKind = LK_INVWAIT;
            newDir         = otherSharers;
            strobe.cmd     = MC_INVREQ;
            msgDst         = otherSharers;
          end
        end
        LK_OWNED: begin
          strobe.wrState = 1'b1;
          strobe.sendMsg = 1'b1;
          strobe.newKind = LK_RECALL;
          strobe.cmd     = reqEx ? MC_FLUSHRQ : MC_WBREQ;
          msgDst         = ownerMask;
        end
        default: ;
      endcase
    end
  end

  // a request against a transient line neither advances nor talks
  p_transient_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (curKind == LK_INVWAIT || curKind == LK_RECALL))
      |-> (!reqReady && !strobe.sendMsg));

endmodule

// File: rtl/homeDirData.sv
`timescale 1ns/1ps
module homeDirData
  import homeDirPkg::*;
#(
  parameter int NUM_CHILD = 4,
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  localparam int ID_W   = $clog2(NUM_CHILD),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINE_W-1:0]    selLine,
  input  ctlStrobe_t           strobe,
  input  logic [NUM_CHILD-1:0] newDir,
  input  logic [ID_W-1:0]      newOwner,
  input  logic [NUM_CHILD-1:0] msgDst,
  input  logic [DATA_W-1:0]    wrData,
  output lineKind_e            curKind,
  output logic [NUM_CHILD-1:0] curDir,
  output logic [ID_W-1:0]      curOwner,
  output logic                 outValid,
  output logic [2:0]           outCmd,
  output logic [NUM_CHILD-1:0] outDst,
  output logic [LINE_W-1:0]    outLine,
  output logic [DATA_W-1:0]    outData
);

  lineKind_e            kindQ  [NUM_LINES];
  logic [NUM_CHILD-1:0] dirQ   [NUM_LINES];
  logic [ID_W-1:0]      ownerQ [NUM_LINES];
  logic [DATA_W-1:0]    memQ   [NUM_LINES];

  assign curKind  = kindQ[selLine];
  assign curDir   = dirQ[selLine];
  assign curOwner = ownerQ[selLine];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        kindQ[g]  <= LK_SHARED;
        dirQ[g]   <= '0;
        ownerQ[g] <= '0;
        memQ[g]   <= '0;
      end else if (selLine == LINE_W'(g)) begin
        if (strobe.wrState) begin
          kindQ[g]  <= strobe.newKind;
          dirQ[g]   <= newDir;
          ownerQ[g] <= newOwner;
        end
        if (strobe.wrMem) memQ[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCmd   <= '0;
      outDst   <= '0;
      outLine  <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobe.sendMsg;
      outCmd   <= strobe.cmd;
      outDst   <= msgDst;
      outLine  <= selLine;
      outData  <= memQ[selLine];
    end
  end

  // an invalidating line always still waits on at least one acknowledge
  p_invwait_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curKind == LK_INVWAIT) |-> (curDir != '0));

endmodule

// File: rtl/homeDirectory.sv
`timescale 1ns/1ps
module homeDirectory
  import homeDirPkg::*;
#(
  parameter int NUM_CHILD = 4,
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  localparam int ID_W   = $clog2(NUM_CHILD),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqSrc,
  input  logic                 reqEx,
  input  logic [LINE_W-1:0]    reqLine,
  output logic                 reqReady,
  input  logic                 rspValid,
  input  logic [ID_W-1:0]      rspSrc,
  input  logic [1:0]           rspCmd,
  input  logic [LINE_W-1:0]    rspLine,
  input  logic [DATA_W-1:0]    rspData,
  output logic                 outValid,
  output logic [2:0]           outCmd,
  output logic [NUM_CHILD-1:0] outDst,
  output logic [LINE_W-1:0]    outLine,
  output logic [DATA_W-1:0]    outData
);

  ctlStrobe_t           strobe;
  lineKind_e            curKind;
  logic [NUM_CHILD-1:0] curDir, newDir, msgDst;
  logic [ID_W-1:0]      curOwner, newOwner;
  logic [LINE_W-1:0]    selLine;

  // replies own the directory port whenever present
  assign selLine = rspValid ? rspLine : reqLine;

  homeDirCtl #(.NUM_CHILD(NUM_CHILD)) ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqEx(reqEx),
    .rspValid(rspValid), .rspSrc(rspSrc), .rspCmd(rspCmd),
    .curKind(curKind), .curDir(curDir), .curOwner(curOwner),
    .reqReady(reqReady), .strobe(strobe),
    .newDir(newDir), .newOwner(newOwner), .msgDst(msgDst)
  );

  homeDirData #(.NUM_CHILD(NUM_CHILD), .NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .selLine(selLine),
    .strobe(strobe), .newDir(newDir), .newOwner(newOwner), .msgDst(msgDst),
    .wrData(rspData),
    .curKind(curKind), .curDir(curDir), .curOwner(curOwner),
    .outValid(outValid), .outCmd(outCmd), .outDst(outDst),
    .outLine(outLine), .outData(outData)
  );

  p_shared_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqEx)
      |=> (outValid && outCmd == MC_SHREP && outDst == (NUM_CHILD'(1) << $past(reqSrc))));

  p_excl_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == MC_EXREP) |-> ($countones(outDst) == 1));

  p_inv_skips_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == MC_INVREQ)
      |-> (outDst != '0 && (outDst & (NUM_CHILD'(1) << $past(reqSrc))) == '0));

  p_recall_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outCmd == MC_WBREQ || outCmd == MC_FLUSHRQ || outCmd == MC_INVREQ))
      |-> !$past(reqReady));

  p_reply_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  p_reply_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !outValid);

endmodule

// File: tb/homeDirectory_test.sv
`timescale 1ns/1ps
module homeDirectory_test;

  localparam int NC = 4;
  localparam int NL = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqEx = 1'b0, reqReady;
  logic [1:0] reqSrc = '0, reqLine = '0;
  logic rspValid = 1'b0;
  logic [1:0] rspSrc = '0, rspCmd = '0, rspLine = '0;
  logic [DW-1:0] rspData = '0;
  logic outValid;
  logic [2:0] outCmd;
  logic [NC-1:0] outDst;
  logic [1:0] outLine;
  logic [DW-1:0] outData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NC-1:0] dst;
    logic [2:0]    cmd;
    logic [1:0]    line;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  homeDirectory #(.NUM_CHILD(NC), .NUM_LINES(NL), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqEx(reqEx), .reqLine(reqLine),
    .reqReady(reqReady),
    .rspValid(rspValid), .rspSrc(rspSrc), .rspCmd(rspCmd), .rspLine(rspLine),
    .rspData(rspData),
    .outValid(outValid), .outCmd(outCmd), .outDst(outDst),
    .outLine(outLine), .outData(outData)
  );

  // monitor: every produced message is matched against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL unexpected message cmd=%0d dst=%b line=%0d exp=none", outCmd, outDst, outLine);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (outCmd !== e.cmd || outDst !== e.dst || outLine !== e.line ||
            (e.cmd <= 3'd1 && outData !== e.data)) begin
          bad++;
          $display("FAIL %s: got cmd=%0d dst=%b line=%0d data=%h exp cmd=%0d dst=%b line=%0d data=%h",
                   e.tag, outCmd, outDst, outLine, outData, e.cmd, e.dst, e.line, e.data);
        end
      end
    end
  end

  task automatic expect_msg(input logic [2:0] cmd, input logic [NC-1:0] dst,
                            input logic [1:0] line, input logic [DW-1:0] data, input string tag);
    exp_t e;
    e.cmd = cmd; e.dst = dst; e.line = line; e.data = data; e.tag = tag;
    sb.push_back(e);
  endtask

  // one cycle of stimulus, then check the dequeue strobe mid-cycle
  task automatic go(input logic rv, input logic [1:0] src, input logic ex, input logic [1:0] line,
                    input logic pv, input logic [1:0] psrc, input logic [1:0] pcmd,
                    input logic [1:0] pline, input logic [DW-1:0] pdata,
                    input logic expReady, input string tag);
    @(posedge clk); #1;
    reqValid = rv; reqSrc = src; reqEx = ex; reqLine = line;
    rspValid = pv; rspSrc = psrc; rspCmd = pcmd; rspLine = pline; rspData = pdata;
    @(negedge clk);
    total++;
    if (reqReady !== expReady) begin
      bad++;
      $display("FAIL %s: reqReady=%b exp=%b", tag, reqReady, expReady);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, "idle");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0 || reqReady !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs: outValid=%b reqReady=%b exp=0 0", outValid, reqReady);
    end

    // R1/R2: first reader sees zero data; second reader added
    expect_msg(3'd0, 4'b0001, 2'd0, 32'h0, "R1 R2 shared reply c0");
    go(1, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1, "R2 shared dequeue c0");
    expect_msg(3'd0, 4'b0010, 2'd0, 32'h0, "R2 shared reply c1");
    go(1, 1, 0, 0, 0, 0, 0, 0, 0, 1'b1, "R2 shared dequeue c1");

    // R4: exclusive from c2 with sharers c0,c1
    expect_msg(3'd2, 4'b0011, 2'd0, 32'h0, "R4 invalidate others");
    go(1, 2, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R4 exclusive held");
    go(1, 2, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R6 held on transient, silent");
    go(1, 2, 1, 0, 1, 0, 2'd0, 0, 0, 1'b0, "R10 ack c0 with request waiting");
    go(1, 2, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R7 one ack still pending");
    go(1, 2, 1, 0, 1, 1, 2'd0, 0, 0, 1'b0, "R10 ack c1 with request waiting");
    expect_msg(3'd1, 4'b0100, 2'd0, 32'h0, "R7 R3 grant after last ack");
    go(1, 2, 1, 0, 0, 0, 0, 0, 0, 1'b1, "R7 exclusive granted");

    // R5/R8: shared request to owned line -> write-back recall
    expect_msg(3'd3, 4'b0100, 2'd0, 32'h0, "R5 write-back request to owner");
    go(1, 3, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R5 shared held on owned");
    go(1, 3, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R6 recall pending silent");
    go(1, 3, 0, 0, 1, 2, 2'd1, 0, 32'hA5A5_0001, 1'b0, "R10 write-back consumed");
    expect_msg(3'd0, 4'b1000, 2'd0, 32'hA5A5_0001, "R8 reply carries written-back data");
    go(1, 3, 0, 0, 0, 0, 0, 0, 0, 1'b1, "R8 shared granted");

    // R8: former owner kept as sharer -> exclusive by c3 invalidates c2
    expect_msg(3'd2, 4'b0100, 2'd0, 32'h0, "R8 former owner still sharer");
    go(1, 3, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R4 exclusive held c3");
    go(1, 3, 1, 0, 1, 2, 2'd0, 0, 0, 1'b0, "R10 ack c2");
    expect_msg(3'd1, 4'b1000, 2'd0, 32'hA5A5_0001, "R3 grant to c3");
    go(1, 3, 1, 0, 0, 0, 0, 0, 0, 1'b1, "R3 exclusive granted c3");

    // R5/R9: exclusive to owned line -> flush
    expect_msg(3'd4, 4'b1000, 2'd0, 32'h0, "R5 flush request to owner");
    go(1, 1, 1, 0, 0, 0, 0, 0, 0, 1'b0, "R5 exclusive held on owned");
    go(1, 1, 1, 0, 1, 3, 2'd2, 0, 32'h0000_1234, 1'b0, "R10 flush consumed");
    expect_msg(3'd1, 4'b0010, 2'd0, 32'h0000_1234, "R9 no sharer left, direct grant");
    go(1, 1, 1, 0, 0, 0, 0, 0, 0, 1'b1, "R9 exclusive granted c1");

    // R3: requester is the only sharer; line 1 independent, zero data
    expect_msg(3'd0, 4'b0001, 2'd1, 32'h0, "R1 line1 reads zero");
    go(1, 0, 0, 1, 0, 0, 0, 0, 0, 1'b1, "R2 line1 shared c0");
    expect_msg(3'd1, 4'b0001, 2'd1, 32'h0, "R3 upgrade by sole sharer");
    go(1, 0, 1, 1, 0, 0, 0, 0, 0, 1'b1, "R3 sole sharer dequeued");

    // R7: voluntary ack in shared state removes the sharer
    expect_msg(3'd0, 4'b0010, 2'd2, 32'h0, "R2 line2 c1");
    go(1, 1, 0, 2, 0, 0, 0, 0, 0, 1'b1, "R2 line2 c1 dequeue");
    expect_msg(3'd0, 4'b0100, 2'd2, 32'h0, "R2 line2 c2");
    go(1, 2, 0, 2, 0, 0, 0, 0, 0, 1'b1, "R2 line2 c2 dequeue");
    go(0, 0, 0, 0, 1, 1, 2'd0, 2, 0, 1'b0, "R7 voluntary ack c1");
    expect_msg(3'd1, 4'b0100, 2'd2, 32'h0, "R7 removed sharer not invalidated");
    go(1, 2, 1, 2, 0, 0, 0, 0, 0, 1'b1, "R7 exclusive direct after ack");

    idle(3);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 missing messages: pending=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule